// File: doc/BRIEF.md
# Shared-Byte Memory with Multiplexed Address/Data Ports

This block is a 256-byte store that two independent agents, called A and B, can both use. Each agent has one 8-bit bus. The bus first carries an address and later carries data. Each agent also has three active-low strobes: a select, a write strobe and a read strobe. Either agent can reach every byte. No hardware arbitration exists between the agents. Software is expected to keep apart any writes that could collide.

The model is synchronous. A system clock samples every strobe through a two-stage synchroniser, and all edges are detected on the synchronised copies. When the select strobe falls, the port latches the address on its bus. A read strobe that follows then returns the stored byte on the bus. A write strobe that follows instead stores a byte. The write lands when the first of the select or write strobes rises, using the byte present on the bus at that moment. The bidirectional bus appears as three signals: an input, an output and an output-enable. The output-enable is driven only when the port is actually performing a read.

Top module: `dual_port_mux_ram`

## Requirements
- R1: After synchronous reset, both ports hold their bus output-enable low.
- R2: A port latches its address from the bus when its select strobe falls. After that, changing the bus value has no effect on which byte is read or written.
- R3: Suppose select is low, write strobe is high and the read strobe falls. Within four clock cycles of the read strobe falling, the port raises bus output-enable and drives the byte stored at the latched address. It keeps doing so while both strobes stay low.
- R4: A read ends at the first rising edge of either select or read strobe. Within four clock cycles, bus output-enable is low again.
- R5: A write occurs when the write strobe is low while select is low. It stores the bus value seen when the first of select or write strobe rises. The byte goes to the latched address.
- R6: A port never asserts its bus output-enable while its write strobe is low, even if select and the read strobe are also low.
- R7: Both ports may read the same location at once, and each port returns the stored byte.
- R8: If both ports commit a write to the same address in the same clock cycle, port A's byte is kept and port B's write is discarded.
- R9: A port may start reading in the same cycle that the other port's write to that address lands. Its first driven cycle shows the byte from before the write. The next cycle shows the new byte.
- R10: Addresses 0x00 and 0xFF, and the addresses between them, are reachable for both writing and reading from either port.
- R11: A read sequence leaves memory unchanged, even when a different value sits on the bus while the read strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| a_en_n | input | 1 | Port A select, active low |
| a_we_n | input | 1 | Port A write strobe, active low |
| a_oe_n | input | 1 | Port A read strobe, active low |
| a_bus_in | input | 8 | Port A bus value seen by the block |
| a_bus_out | output | 8 | Port A byte driven during a read |
| a_bus_oe | output | 1 | Port A bus drive enable |
| b_en_n | input | 1 | Port B select, active low |
| b_we_n | input | 1 | Port B write strobe, active low |
| b_oe_n | input | 1 | Port B read strobe, active low |
| b_bus_in | input | 8 | Port B bus value seen by the block |
| b_bus_out | output | 8 | Port B byte driven during a read |
| b_bus_oe | output | 1 | Port B bus drive enable |

## Verification
A latched address that drifts from its captured value shows up as a wrong byte during the next read on that port. That is at most four cycles after its read strobe falls. A stale or mis-timed strobe state in the edge detector shows up in one of two ways: as a bus drive-enable that stays high beyond four cycles after a strobe rises, or as a write that is lost or stored twice. The bench sees such a fault at the next read-back. Read-data register staging is exposed directly by the same-cycle read-during-write case: a wrong stage shows the new byte one cycle early, or the old byte one cycle too long. The write priority between ports is exposed by a single colliding commit.

// File: rtl/dpram_pkg.sv
package dpram_pkg;
    parameter int BUS_W       = 8;
    parameter int SYNC_STAGES = 2;
    parameter int NUM_PORTS   = 2;
    localparam int DEPTH      = 1 << BUS_W;

    typedef logic [BUS_W-1:0] word_t;

    typedef struct packed {
        logic sel_n;
        logic wr_n;
        logic rd_n;
    } strobe_t;

    typedef struct packed {
        logic  valid;
        word_t addr;
        word_t data;
    } wr_req_t;

    function automatic logic in_write(strobe_t s);
        return !s.sel_n && !s.wr_n;
    endfunction

    function automatic logic in_read(strobe_t s);
        return !s.sel_n && !s.rd_n && s.wr_n;
    endfunction
endpackage

// File: rtl/dpram_sync.sv
module dpram_sync #(
    parameter int          W       = 3,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= RST_VAL;
        end else begin
            chain[0] <= d;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/dpram_port.sv
module dpram_port
    import dpram_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  strobe_t strobe_raw,
    input  word_t   bus_in,
    input  word_t   rd_word,
    output word_t   lat_addr,
    output wr_req_t wr,
    output word_t   bus_out,
    output logic    bus_oe
);
    strobe_t cur_s;
    strobe_t prev_s;
    logic    capture;
    logic    commit;
    word_t   addr_q;
    word_t   rd_q;
    logic    drive_q;

    dpram_sync #(.W($bits(strobe_t)), .STAGES(SYNC_STAGES), .RST_VAL('1)) sync_i (
        .clk (clk),
        .rst (rst),
        .d   (strobe_raw),
        .q   (cur_s)
    );

    assign capture = prev_s.sel_n && !cur_s.sel_n;
    assign commit  = in_write(prev_s) && !in_write(cur_s);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_s  <= '1;
            addr_q  <= '0;
            rd_q    <= '0;
            drive_q <= 1'b0;
        end else begin
            prev_s  <= cur_s;
            if (capture) addr_q <= bus_in;
            rd_q    <= rd_word;
            drive_q <= in_read(cur_s);
        end
    end

    assign lat_addr = addr_q;
    assign wr       = '{valid: commit, addr: addr_q, data: bus_in};
    assign bus_out  = rd_q;
    assign bus_oe   = drive_q;

    // R6
    drive_vs_write_chk: assert property (@(posedge clk) disable iff (rst)
        commit |-> !bus_oe);

    // R2
    addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !capture |=> $stable(addr_q));

    // R4
    read_end_chk: assert property (@(posedge clk) disable iff (rst)
        (!prev_s.sel_n && cur_s.sel_n) || (!prev_s.rd_n && cur_s.rd_n) |=> !bus_oe);
endmodule

// File: rtl/dpram_mem.sv
module dpram_mem
    import dpram_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  wr_req_t [NUM_PORTS-1:0]  wr,
    input  word_t   [NUM_PORTS-1:0]  rd_addr,
    output word_t   [NUM_PORTS-1:0]  rd_data
);
    word_t store [DEPTH];

    // lower port index is applied last and therefore wins a collision
    always_ff @(posedge clk) begin
        for (int p = NUM_PORTS - 1; p >= 0; p--) begin
            if (wr[p].valid) store[wr[p].addr] <= wr[p].data;
        end
    end

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_rd
        assign rd_data[p] = store[rd_addr[p]];
    end

    if (NUM_PORTS >= 2) begin : g_prio
        // R8
        a_wins_chk: assert property (@(posedge clk) disable iff (rst)
            (wr[0].valid && wr[1].valid && wr[0].addr == wr[1].addr)
            |=> store[$past(wr[0].addr)] == $past(wr[0].data));
        // R5
        b_lands_chk: assert property (@(posedge clk) disable iff (rst)
            (wr[1].valid && !(wr[0].valid && wr[0].addr == wr[1].addr))
            |=> store[$past(wr[1].addr)] == $past(wr[1].data));
    end
endmodule

// File: rtl/dual_port_mux_ram.sv
module dual_port_mux_ram
    import dpram_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             a_en_n,
    input  logic             a_we_n,
    input  logic             a_oe_n,
    input  logic [BUS_W-1:0] a_bus_in,
    output logic [BUS_W-1:0] a_bus_out,
    output logic             a_bus_oe,
    input  logic             b_en_n,
    input  logic             b_we_n,
    input  logic             b_oe_n,
    input  logic [BUS_W-1:0] b_bus_in,
    output logic [BUS_W-1:0] b_bus_out,
    output logic             b_bus_oe
);
    strobe_t [NUM_PORTS-1:0] strobes;
    word_t   [NUM_PORTS-1:0] bus_in_v;
    word_t   [NUM_PORTS-1:0] bus_out_v;
    logic    [NUM_PORTS-1:0] bus_oe_v;
    word_t   [NUM_PORTS-1:0] addr_v;
    word_t   [NUM_PORTS-1:0] rd_v;
    wr_req_t [NUM_PORTS-1:0] wr_v;

    assign strobes[0]  = '{sel_n: a_en_n, wr_n: a_we_n, rd_n: a_oe_n};
    assign strobes[1]  = '{sel_n: b_en_n, wr_n: b_we_n, rd_n: b_oe_n};
    assign bus_in_v[0] = a_bus_in;
    assign bus_in_v[1] = b_bus_in;
    assign a_bus_out   = bus_out_v[0];
    assign a_bus_oe    = bus_oe_v[0];
    assign b_bus_out   = bus_out_v[1];
    assign b_bus_oe    = bus_oe_v[1];

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        dpram_port port_i (
            .clk        (clk),
            .rst        (rst),
            .strobe_raw (strobes[p]),
            .bus_in     (bus_in_v[p]),
            .rd_word    (rd_v[p]),
            .lat_addr   (addr_v[p]),
            .wr         (wr_v[p]),
            .bus_out    (bus_out_v[p]),
            .bus_oe     (bus_oe_v[p])
        );
    end

    dpram_mem mem_i (
        .clk     (clk),
        .rst     (rst),
        .wr      (wr_v),
        .rd_addr (addr_v),
        .rd_data (rd_v)
    );
endmodule

// File: tb/dual_port_mux_ram_tb_top.sv
`timescale 1ns/1ps
module dual_port_mux_ram_tb_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic       en_n [2];
    logic       we_n [2];
    logic       oe_n [2];
    logic [7:0] bin  [2];
    logic [7:0] bout [2];
    logic       boe  [2];

    int errors = 0;
    int checks = 0;
    bit done   = 0;

    dual_port_mux_ram dut_i (
        .clk(clk), .rst(rst),
        .a_en_n(en_n[0]), .a_we_n(we_n[0]), .a_oe_n(oe_n[0]),
        .a_bus_in(bin[0]), .a_bus_out(bout[0]), .a_bus_oe(boe[0]),
        .b_en_n(en_n[1]), .b_we_n(we_n[1]), .b_oe_n(oe_n[1]),
        .b_bus_in(bin[1]), .b_bus_out(bout[1]), .b_bus_oe(boe[1])
    );

    // address in upper byte, data in lower byte
    localparam logic [15:0] VEC [6] = '{16'h00_3C, 16'hFF_C3, 16'h01_5A,
                                        16'h80_A5, 16'h7F_00, 16'hFE_FF};

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic waitn(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_write(int p, logic [7:0] addr, logic [7:0] data);
        @(negedge clk); bin[p] = addr; en_n[p] = 1'b0;
        waitn(4); bin[p] = data; we_n[p] = 1'b0;
        waitn(4); we_n[p] = 1'b1;
        waitn(4); en_n[p] = 1'b1; bin[p] = 8'hEE;
        waitn(4);
    endtask

    task automatic do_read(int p, logic [7:0] addr, logic [7:0] exp, string req);
        @(negedge clk); bin[p] = addr; en_n[p] = 1'b0;
        waitn(4); bin[p] = 8'hA5; oe_n[p] = 1'b0;   // R2 bus change after latch
        waitn(4);
        chk({req, " drive"}, {7'd0, boe[p]}, 8'd1);
        chk(req, bout[p], exp);
        oe_n[p] = 1'b1;
        waitn(4);
        chk("R4 end on read strobe", {7'd0, boe[p]}, 8'd0);
        en_n[p] = 1'b1;
        waitn(4);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int p = 0; p < 2; p++) begin
            en_n[p] = 1'b1; we_n[p] = 1'b1; oe_n[p] = 1'b1; bin[p] = 8'h00;
        end
        waitn(4);
        rst = 1'b0;
        waitn(1);
        // R1
        chk("R1 a_bus_oe", {7'd0, boe[0]}, 8'd0);
        chk("R1 b_bus_oe", {7'd0, boe[1]}, 8'd0);

        // R3 R5 R10: table walk, write on one port, read on the other
        for (int i = 0; i < 6; i++) begin
            do_write(i % 2, VEC[i][15:8], VEC[i][7:0]);
            do_read(1 - (i % 2), VEC[i][15:8], VEC[i][7:0], "R3 R5 R10 table");
        end

        // R11: re-read after read sequences left junk on the bus
        do_read(0, 8'h01, 8'h5A, "R11 read leaves memory");
        do_read(1, 8'hFF, 8'hC3, "R11 read leaves memory");

        // R6: all strobes low, no drive
        @(negedge clk); bin[0] = 8'h20; en_n[0] = 1'b0;
        waitn(4); bin[0] = 8'h55; we_n[0] = 1'b0; oe_n[0] = 1'b0;
        waitn(4);
        chk("R6 no drive while write strobe low", {7'd0, boe[0]}, 8'd0);
        oe_n[0] = 1'b1;
        waitn(4); we_n[0] = 1'b1;
        waitn(4); en_n[0] = 1'b1;
        waitn(4);
        do_read(1, 8'h20, 8'h55, "R5 write after R6 case");

        // R4: read ended by select rising first
        @(negedge clk); bin[1] = 8'h00; en_n[1] = 1'b0;
        waitn(4); oe_n[1] = 1'b0;
        waitn(4);
        chk("R3 drive before select rise", bout[1], 8'h3C);
        en_n[1] = 1'b1;
        waitn(4);
        chk("R4 end on select", {7'd0, boe[1]}, 8'd0);
        oe_n[1] = 1'b1;
        waitn(4);

        // R7: simultaneous read of the same byte
        @(negedge clk); bin[0] = 8'hFE; bin[1] = 8'hFE; en_n[0] = 1'b0; en_n[1] = 1'b0;
        waitn(4); oe_n[0] = 1'b0; oe_n[1] = 1'b0;
        waitn(4);
        chk("R7 port A", bout[0], 8'hFF);
        chk("R7 port B", bout[1], 8'hFF);
        chk("R7 both drive", {6'd0, boe[0], boe[1]}, 8'd3);
        oe_n[0] = 1'b1; oe_n[1] = 1'b1;
        waitn(4); en_n[0] = 1'b1; en_n[1] = 1'b1;
        waitn(4);

        // R8: colliding commits, A wins
        @(negedge clk); bin[0] = 8'h77; bin[1] = 8'h77; en_n[0] = 1'b0; en_n[1] = 1'b0;
        waitn(4); bin[0] = 8'hA1; bin[1] = 8'hB2; we_n[0] = 1'b0; we_n[1] = 1'b0;
        waitn(4); we_n[0] = 1'b1; we_n[1] = 1'b1;
        waitn(4); en_n[0] = 1'b1; en_n[1] = 1'b1;
        waitn(4);
        do_read(1, 8'h77, 8'hA1, "R8 port A wins");

        // R9: read starts the same cycle the other port's write lands
        do_write(0, 8'h40, 8'h11);
        @(negedge clk); bin[1] = 8'h40; en_n[1] = 1'b0; bin[0] = 8'h40; en_n[0] = 1'b0;
        waitn(4); bin[0] = 8'h99; we_n[0] = 1'b0;
        waitn(4); we_n[0] = 1'b1; oe_n[1] = 1'b0;
        waitn(3);
        chk("R9 drive on first cycle", {7'd0, boe[1]}, 8'd1);
        chk("R9 old byte first", bout[1], 8'h11);
        waitn(1);
        chk("R9 new byte next", bout[1], 8'h99);
        oe_n[1] = 1'b1;
        waitn(4); en_n[0] = 1'b1; en_n[1] = 1'b1;
        waitn(4);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule